// File: doc/BRIEF.md
# MII Management Register Bridge

This block connects one 32-bit host command register to a two-wire serial management bus that reaches a single PHY. Software writes a command word holding a handshake flag in bit 31, a PHY register number in bits 20:16 and a 16-bit data value in bits 15:0. The bridge then sends one complete management frame: a 32-bit preamble of ones, the start pattern 01, an opcode (01 to write, 10 to read), a fixed PHY address, the register number, a two-bit turnaround and sixteen data bits, most significant bit first.

The flag works in opposite ways for the two directions. A write is requested with the flag set, and the bridge clears the flag when the frame has left the wire. A read is requested with the flag clear, and the bridge sets the flag in the same cycle that the captured data appears in bits 15:0. Software polls the register until the flag has flipped. The management clock is the system clock divided by a parameter. Each bit slot spends `HALF_DIV` cycles low and then `HALF_DIV` cycles high.

Top module: `mdio_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `mdc`, `mdio_o` and `mdio_oe` are low, and `cmd_rdata` reads 0.
- R2: A host write with bit 31 set, accepted while idle, raises `busy` on the next cycle. The bridge drives the whole frame with `mdio_oe` high: 32 ones, then 01, then 01, then `PHY_ADDR`, then the register number, then 10, then data[15:0], MSB first. Bit slot k of the frame starts 1 + 2·HALF_DIV·k cycles after the accepting edge.
- R3: At the end of a write frame, bit 31 of `cmd_rdata` goes to 0 and bits 15:0 keep the written data.
- R4: A read frame drives the opcode 10 and drives the first turnaround bit as 1. `mdio_oe` is low from the second turnaround bit (slot 47) until the frame ends.
- R5: During a read, `mdio_i` is sampled on each rising `mdc` edge of slots 48 to 63. At completion bit 31 goes to 1 and bits 15:0 hold those sixteen samples, the first sample as the MSB.
- R6: Only bits 20:16 select the register. Bits 30:21 of a command never reach the frame and always read back as 0.
- R7: `mdc` is low whenever the bridge is idle. In every bit slot it is low for `HALF_DIV` cycles and then high for `HALF_DIV` cycles, and the default gives a period of at least 400 ns at a 10 ns clock.
- R8: While `busy` is high, a new command is ignored and `cmd_rdata` holds the accepted word. That word is the flag as written, bits 30:21 zeroed, the register number and the data.
- R9: While idle, `cmd_rdata` returns the last completed word, with the flag and the data.
- R10: `busy` stays high for exactly 64·2·HALF_DIV cycles, which is 25.6 µs with the defaults and well inside a 500 µs polling window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Host write strobe for the command register |
| cmd_wdata | input | 32 | Command word being written |
| cmd_rdata | output | 32 | Command register read value |
| busy | output | 1 | High from command accept until completion |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
All registered results move on the first rising edge after their cause. `busy` and the new word appear one cycle after the accepting write. The `mdc` phase and the frame bit change at the start of each slot, spaced every 2·HALF_DIV cycles. The flag flip, the read data and the fall of `busy` all land together 64·2·HALF_DIV cycles after acceptance. The bench moves a behavioural model on the rising edge, using the same inputs the design sees, and compares every output on the falling edge, so each expected value is checked in the exact cycle it is due. The PHY reply is likewise presented on the falling edge, so it is stable at the rising `mdc` edge where it is sampled.

// File: rtl/mdio_bridge.sv
module mdio_bridge #(
  parameter int HALF_DIV = 20,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int SLOT_CYC = 2 * HALF_DIV;
  localparam int DW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [5:0] LAST_SLOT = 6'd63;
  localparam logic [5:0] RELEASE_SLOT = 6'd47;
  localparam logic [5:0] DATA_SLOT = 6'd48;

  logic [DW-1:0] div_q;
  logic [5:0]    slot_q;
  logic [63:0]   sh_q;
  logic [15:0]   rd_q;
  logic [31:0]   word_q;
  logic          busy_q;
  logic          rd_op_q;

  wire wr_req    = cmd_wdata[31];
  wire accept    = cmd_we && !busy_q;
  wire slot_end  = div_q == DW'(SLOT_CYC - 1);
  wire rise_edge = div_q == DW'(HALF_DIV - 1);
  wire unused_hi = ^cmd_wdata[30:21];

  wire [63:0] frame_new = {32'hFFFF_FFFF, 2'b01,
                           wr_req ? 2'b01 : 2'b10,
                           PHY_ADDR, cmd_wdata[20:16],
                           wr_req ? 2'b10 : 2'b11,
                           wr_req ? cmd_wdata[15:0] : 16'hFFFF};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      slot_q  <= '0;
      sh_q    <= '0;
      rd_q    <= '0;
      word_q  <= '0;
      busy_q  <= 1'b0;
      rd_op_q <= 1'b0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      rd_op_q <= !wr_req;
      div_q   <= '0;
      slot_q  <= '0;
      sh_q    <= frame_new;
      word_q  <= {wr_req, 10'b0, cmd_wdata[20:16], cmd_wdata[15:0]};
    end else if (busy_q) begin
      if (rd_op_q && rise_edge && slot_q >= DATA_SLOT)
        rd_q <= {rd_q[14:0], mdio_i};
      if (slot_end) begin
        div_q <= '0;
        if (slot_q == LAST_SLOT) begin
          busy_q <= 1'b0;
          word_q <= {~word_q[31], word_q[30:16], rd_op_q ? rd_q : word_q[15:0]};
        end else begin
          slot_q <= slot_q + 6'd1;
          sh_q   <= {sh_q[62:0], 1'b0};
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign busy      = busy_q;
  assign cmd_rdata = word_q;
  assign mdc       = busy_q && (div_q >= DW'(HALF_DIV));
  assign mdio_oe   = busy_q && !(rd_op_q && slot_q >= RELEASE_SLOT);
  assign mdio_o    = mdio_oe && sh_q[63];
endmodule

module mdio_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_oe,
  input logic [31:0] cmd_rdata
);
  logic       mdc_q;
  logic [6:0] falls_q;
  wire  [6:0] slot_now = falls_q + {6'b0, mdc_q && !mdc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_q   <= 1'b0;
      falls_q <= '0;
    end else begin
      mdc_q   <= mdc;
      falls_q <= busy ? slot_now : 7'd0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R7
  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_rdata[31]) |-> mdio_oe); // R2
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_rdata[31]) |-> (mdio_oe == (slot_now < 7'd47))); // R4
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_rdata)); // R8
  AST_FLAG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cmd_rdata[31] != $past(cmd_rdata[31]))); // R3
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdata[30:21] == 10'd0); // R6
endmodule

bind mdio_bridge mdio_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc),
  .mdio_oe(mdio_oe), .cmd_rdata(cmd_rdata)
);

// File: tb/mdio_bridge_test.sv
module mdio_bridge_test;
  localparam int CLK_NS = 10;
  localparam int HALF = 20;
  localparam logic [4:0] PA = 5'd1;
  localparam int FRAME_CYC = 64 * 2 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic mdio_i = 1'b1;
  logic [31:0] cmd_rdata;
  logic busy, mdc, mdio_o, mdio_oe;

  mdio_bridge #(.HALF_DIV(HALF), .PHY_ADDR(PA)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int total_cyc = 0;
  int busy_len = 0;

  bit          m_busy = 0;
  bit          m_read = 0;
  int          m_cyc = 0;
  logic [31:0] m_word = '0;
  logic [63:0] m_frame = '0;
  logic [15:0] reply = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mk_frame(input logic wr, input logic [4:0] ra, input logic [15:0] d);
    logic [63:0] f;
    f = '1;
    f[31:30] = 2'b01;
    f[29:28] = wr ? 2'b01 : 2'b10;
    f[27:23] = PA;
    f[22:18] = ra;
    f[17:16] = wr ? 2'b10 : 2'b11;
    f[15:0]  = wr ? d : 16'hFFFF;
    return f;
  endfunction

  always @(posedge clk) begin
    total_cyc++;
    if (!rst_n) begin
      m_busy = 0; m_cyc = 0; m_word = '0; m_read = 0;
    end else if (m_busy) begin
      if (m_cyc == FRAME_CYC - 1) begin
        m_busy = 0;
        m_word[31] = ~m_word[31];
        if (m_read) m_word[15:0] = reply;
      end else m_cyc++;
    end else if (cmd_we) begin
      m_busy = 1; m_cyc = 0;
      m_read = !cmd_wdata[31];
      m_word = {cmd_wdata[31], 10'b0, cmd_wdata[20:16], cmd_wdata[15:0]};
      m_frame = mk_frame(cmd_wdata[31], cmd_wdata[20:16], cmd_wdata[15:0]);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int slot;
      logic e_mdc, e_oe, e_o;
      slot  = m_cyc / (2 * HALF);
      e_mdc = m_busy && ((m_cyc % (2 * HALF)) >= HALF);
      e_oe  = m_busy && !(m_read && slot >= 47);
      e_o   = e_oe && m_frame[63 - slot];
      chk("R7 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      chk(m_read ? "R4 mdio_oe" : "R2 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      chk(m_read ? "R4 mdio_o" : "R2 mdio_o", {31'b0, mdio_o}, {31'b0, e_o});
      chk("R8 busy", {31'b0, busy}, {31'b0, m_busy});
      chk(m_busy ? "R8 word" : "R9 word", cmd_rdata, m_word);
      if (busy) busy_len++;
      else if (busy_len > 0) begin
        chk("R10 busy length", busy_len, FRAME_CYC);
        busy_len = 0;
      end
      mdio_i <= (m_busy && m_read && slot >= 48) ? reply[63 - slot] : 1'b1;
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (total_cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", total_cyc);
      finish_run();
    end
  end

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0; cmd_wdata = '0;
  endtask

  task automatic wait_idle;
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'b0, busy}, 32'd0);
    chk("R1 mdc in reset", {30'b0, mdc, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after reset", cmd_rdata, 32'd0);
    chk("R1 mdio_o after reset", {31'b0, mdio_o}, 32'd0);
    chk("R7 period ns", 2 * HALF * CLK_NS >= 400, 1);

    // write with junk in bits 30:21; a second command while busy is dropped
    send(32'hFFFF_A5C3);
    chk("R6 upper bits masked", cmd_rdata, 32'h801F_A5C3);
    repeat (100) @(negedge clk);
    send(32'h8002_1111);
    wait_idle();
    chk("R3 write done", cmd_rdata, 32'h001F_A5C3);
    chk("R8 ignored command", cmd_rdata[20:0], 21'h1F_A5C3);

    reply = 16'h1234;
    send(32'h0003_0000);
    wait_idle();
    chk("R5 read done", cmd_rdata, 32'h8003_1234);

    reply = 16'h8001;
    send(32'h7FE0_0000);
    wait_idle();
    chk("R5 read edge bits", cmd_rdata, 32'h8000_8001);
    chk("R6 read upper zero", {22'b0, cmd_rdata[30:21]}, 32'd0);

    send(32'h8010_0000);
    wait_idle();
    chk("R3 write zero", cmd_rdata, 32'h0010_0000);

    reply = 16'hFFFF;
    send(32'h001A_5555);
    wait_idle();
    chk("R5 read ones", cmd_rdata, 32'h801A_FFFF);
    repeat (10) @(negedge clk);
    chk("R9 idle readback", cmd_rdata, 32'h801A_FFFF);
    chk("R10 window", FRAME_CYC * CLK_NS <= 500000, 1);
    finish_run();
  end
endmodule